// File: doc/BRIEF.md
# Next Program Counter Selector

This block chooses the address of the next instruction for a single-cycle processor core that runs a subset of a common 32-bit RISC instruction set. It holds the program counter in a clocked register and works out, in the same cycle, four candidate successors:
- the sequential address, PC + 4;
- a PC-relative branch target;
- an absolute jump target that stays inside the current 256 MiB region;
- a target taken from a register value.

A two-bit source select from the decoder, together with a branch-taken flag from the equality comparator, picks which candidate is loaded into the register at the next rising edge.

The same block also supplies the return address for jump-and-link, PC + 8, so the register file can write it to general register 31 without an adder of its own. The branch displacement arrives as the raw 16-bit instruction field. The block turns it into a byte displacement by appending two zero bits and sign-extending the 18-bit result. The jump index arrives as the raw 26-bit field.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the program counter `pc` becomes 0x00000000 at that edge.
- R2: At every rising edge with `rst` low, `pc` takes the value that `next_pc` had just before that edge.
- R3: With `pc_sel` = 2'b00 (sequential), `next_pc` equals `pc` + 4 modulo 2^32, whatever the other inputs are.
- R4: With `pc_sel` = 2'b01 (branch) and `br_taken` = 1, `next_pc` equals `pc` + 4 + sign_extend({`br_off`, 2'b00}) modulo 2^32.
- R5: A branch offset with bit 15 set gives a backward target. An offset of 0xFFFF gives `next_pc` = `pc`, and 0x8000 gives `pc` + 4 − 0x20000.
- R6: With `pc_sel` = 2'b01 and `br_taken` = 0, `next_pc` equals `pc` + 4, whatever `br_off` is.
- R7: With `pc_sel` = 2'b10 (absolute jump), `next_pc` equals {`pc`[31:28], `jmp_idx`, 2'b00}.
- R8: With `pc_sel` = 2'b11 (register jump), `next_pc` equals `rs_val` bit for bit, including its two low bits.
- R9: `link_addr` always equals `pc` + 8 modulo 2^32, for every value of `pc_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the program counter loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| br_off | input | 16 | Raw branch displacement field, in instruction words |
| jmp_idx | input | 26 | Raw absolute jump index field |
| rs_val | input | 32 | Register operand used as a register-jump target |
| br_taken | input | 1 | Branch condition result (equal or not-equal already applied) |
| pc_sel | input | 2 | Source select: 00 sequential, 01 branch, 10 jump, 11 register |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address loaded into the counter at the next edge |
| link_addr | output | 32 | Return address PC + 8 for jump-and-link |

## Verification
The program counter is first placed at chosen addresses through the register source. Each select value is then applied from those addresses, so that a wrong leg of the multiplexer shows up as a value that no other leg could give. Branches are tried with small and extreme positive and negative offsets, and with the taken flag both set and clear under a non-zero offset. This separates a missing word scaling, a missing sign extension and a condition that is ignored. Jumps are tried from a PC whose top nibble is non-zero with an all-ones index, which exposes a lost region field or a bad shift. Sequential and link values are checked at the top of the address space, where both must wrap around to low addresses.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN    = 32;
  localparam int OFF_W   = 16;
  localparam int IDX_W   = 26;
  localparam int ALIGN_W = 2;
  localparam int REG_W   = XLEN - IDX_W - ALIGN_W;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'b00,
    SRC_BRANCH = 2'b01,
    SRC_JUMP   = 2'b10,
    SRC_REG    = 2'b11
  } pc_src_e;
endpackage

// File: rtl/npc_branch_calc.sv
module npc_branch_calc #(
  parameter int XLEN    = 32,
  parameter int OFF_W   = 16,
  parameter int ALIGN_W = 2
) (
  input  logic [XLEN-1:0]  seq_pc,
  input  logic [OFF_W-1:0] off,
  output logic [XLEN-1:0]  target
);
  localparam int SCALED_W = OFF_W + ALIGN_W;
  localparam int FILL_W   = XLEN - SCALED_W;

  logic [SCALED_W-1:0] scaled;
  logic [XLEN-1:0]     disp;

  always_comb begin
    scaled = {off, {ALIGN_W{1'b0}}};
    disp   = {{FILL_W{scaled[SCALED_W-1]}}, scaled};
    target = seq_pc + disp;
  end
endmodule

// File: rtl/npc_jump_calc.sv
module npc_jump_calc #(
  parameter int XLEN    = 32,
  parameter int IDX_W   = 26,
  parameter int ALIGN_W = 2,
  parameter int REG_W   = XLEN - IDX_W - ALIGN_W
) (
  input  logic [REG_W-1:0] region,
  input  logic [IDX_W-1:0] idx,
  output logic [XLEN-1:0]  target
);
  always_comb begin
    target = {region, idx, {ALIGN_W{1'b0}}};
  end
endmodule

// File: rtl/npc_select.sv
module npc_select #(
  parameter int XLEN = 32
) (
  input  npc_pkg::pc_src_e src,
  input  logic             taken,
  input  logic [XLEN-1:0]  seq_pc,
  input  logic [XLEN-1:0]  br_pc,
  input  logic [XLEN-1:0]  jmp_pc,
  input  logic [XLEN-1:0]  reg_pc,
  output logic [XLEN-1:0]  nxt
);
  always_comb begin
    unique case (src)
      npc_pkg::SRC_SEQ:    nxt = seq_pc;
      npc_pkg::SRC_BRANCH: nxt = taken ? br_pc : seq_pc;
      npc_pkg::SRC_JUMP:   nxt = jmp_pc;
      npc_pkg::SRC_REG:    nxt = reg_pc;
      default:             nxt = seq_pc;
    endcase
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int               XLEN     = 32,
  parameter logic [XLEN-1:0]  RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_PC;
    else     q <= d;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int                         XLEN     = npc_pkg::XLEN,
  parameter int                         OFF_W    = npc_pkg::OFF_W,
  parameter int                         IDX_W    = npc_pkg::IDX_W,
  parameter logic [npc_pkg::XLEN-1:0]   RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFF_W-1:0] br_off,
  input  logic [IDX_W-1:0] jmp_idx,
  input  logic [XLEN-1:0]  rs_val,
  input  logic             br_taken,
  input  logic [1:0]       pc_sel,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  link_addr
);
  localparam int ALIGN_W = npc_pkg::ALIGN_W;
  localparam int REG_W   = XLEN - IDX_W - ALIGN_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  npc_pkg::pc_src_e src;
  logic [XLEN-1:0]  seq_pc, br_pc, jmp_pc;

  always_comb begin
    src       = npc_pkg::pc_src_e'(pc_sel);
    seq_pc    = pc + STEP;
    link_addr = seq_pc + STEP;
  end

  npc_branch_calc #(.XLEN(XLEN), .OFF_W(OFF_W), .ALIGN_W(ALIGN_W)) i_branch (
    .seq_pc(seq_pc), .off(br_off), .target(br_pc));

  npc_jump_calc #(.XLEN(XLEN), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W), .REG_W(REG_W)) i_jump (
    .region(pc[XLEN-1 -: REG_W]), .idx(jmp_idx), .target(jmp_pc));

  npc_select #(.XLEN(XLEN)) i_sel (
    .src(src), .taken(br_taken), .seq_pc(seq_pc), .br_pc(br_pc),
    .jmp_pc(jmp_pc), .reg_pc(rs_val), .nxt(next_pc));

  npc_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) i_pcr (
    .clk(clk), .rst(rst), .d(next_pc), .q(pc));

  assert_pc_follows_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc == $past(next_pc));

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
    pc_sel == 2'b00 |-> next_pc - pc == STEP);

  assert_not_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b01 && !br_taken) |-> next_pc - pc == STEP);

  assert_jump_region_R7: assert property (@(posedge clk) disable iff (rst)
    pc_sel == 2'b10 |-> (next_pc[XLEN-1 -: REG_W] == pc[XLEN-1 -: REG_W]
                         && next_pc[ALIGN_W-1:0] == '0
                         && next_pc[ALIGN_W +: IDX_W] == jmp_idx));

  assert_reg_jump_R8: assert property (@(posedge clk) disable iff (rst)
    pc_sel == 2'b11 |-> next_pc == rs_val);

  assert_link_R9: assert property (@(posedge clk) disable iff (rst)
    link_addr - pc == XLEN'(8));
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_idx = '0;
  logic [31:0] rs_val = '0;
  logic        br_taken = 1'b0;
  logic [1:0]  pc_sel = 2'b00;
  logic [31:0] pc, next_pc, link_addr;

  int checks = 0;
  int errors = 0;

  npc_unit i_npc_unit (
    .clk(clk), .rst(rst), .br_off(br_off), .jmp_idx(jmp_idx), .rs_val(rs_val),
    .br_taken(br_taken), .pc_sel(pc_sel), .pc(pc), .next_pc(next_pc),
    .link_addr(link_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Place the PC at a chosen address through the register source.
  task automatic place_pc(input logic [31:0] a);
    pc_sel = 2'b11; rs_val = a;
    #1;
    check("R8", next_pc, a);
    tick();
    check("R2", pc, a);
  endtask

  function automatic logic [31:0] br_expect(input logic [31:0] p, input logic [15:0] o);
    logic signed [31:0] d;
    d = 32'(signed'(o)) * 4;
    return p + 32'd4 + d;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    pc_sel = 2'b11; rs_val = 32'h1234_5678;
    tick();
    check("R1", pc, 32'h0);
    tick();
    check("R1", pc, 32'h0);
    rst = 1'b0;
    pc_sel = 2'b00;
    #1;
    check("R3", next_pc, 32'h4);
    check("R9", link_addr, 32'h8);
  endtask

  task automatic t_sequential();
    place_pc(32'h0000_0100);
    pc_sel = 2'b00; br_off = 16'h0040; br_taken = 1'b1; jmp_idx = 26'h155_5555; rs_val = 32'hDEAD_BEEF;
    #1;
    check("R3", next_pc, 32'h0000_0104);
    tick();
    check("R2", pc, 32'h0000_0104);
    place_pc(32'hFFFF_FFFC);
    pc_sel = 2'b00;
    #1;
    check("R3", next_pc, 32'h0);
    check("R9", link_addr, 32'h4);
  endtask

  task automatic t_branch_fwd();
    place_pc(32'h0040_0000);
    pc_sel = 2'b01; br_taken = 1'b1; br_off = 16'h0003;
    #1;
    check("R4", next_pc, br_expect(32'h0040_0000, 16'h0003));
    br_off = 16'h7FFF;
    #1;
    check("R4", next_pc, 32'h0042_0000);
    tick();
    check("R2", pc, 32'h0042_0000);
  endtask

  task automatic t_branch_back();
    place_pc(32'h0040_1000);
    pc_sel = 2'b01; br_taken = 1'b1; br_off = 16'hFFFF;
    #1;
    check("R5", next_pc, 32'h0040_1000);
    br_off = 16'hFFFE;
    #1;
    check("R5", next_pc, 32'h0040_0FFC);
    br_off = 16'h8000;
    #1;
    check("R5", next_pc, 32'h003E_1004);
    check("R5", next_pc, br_expect(32'h0040_1000, 16'h8000));
  endtask

  task automatic t_branch_not_taken();
    place_pc(32'h0000_2000);
    pc_sel = 2'b01; br_taken = 1'b0; br_off = 16'h0100;
    #1;
    check("R6", next_pc, 32'h0000_2004);
    br_off = 16'hFFF0;
    #1;
    check("R6", next_pc, 32'h0000_2004);
    tick();
    check("R6", pc, 32'h0000_2004);
  endtask

  task automatic t_jump();
    place_pc(32'hA000_0010);
    pc_sel = 2'b10; jmp_idx = 26'h3FF_FFFF; rs_val = 32'h0;
    #1;
    check("R7", next_pc, 32'hAFFF_FFFC);
    check("R9", link_addr, 32'hA000_0018);
    jmp_idx = 26'h000_0001;
    #1;
    check("R7", next_pc, 32'hA000_0004);
    tick();
    check("R2", pc, 32'hA000_0004);
  endtask

  task automatic t_reg_jump();
    place_pc(32'h0000_0800);
    pc_sel = 2'b11; rs_val = 32'h8765_4323;
    #1;
    check("R8", next_pc, 32'h8765_4323);
    check("R9", link_addr, 32'h0000_0808);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_sequential();
    t_branch_fwd();
    t_branch_back();
    t_branch_not_taken();
    t_jump();
    t_reg_jump();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule